// File: doc/BRIEF.md
# Transmitter Equalization Phase Sequencer

This block steps one serial-link port through the four-phase transmitter equalization handshake. It runs while link training is in its equalization substate. A single input picks the role. The upstream-facing role starts in phase 0 and reports its preset. The downstream-facing role has no phase 0 and starts in phase 1. A 2-bit control code carries every phase change between the two sides. The block reads this code from received training sets and drives it on transmitted ones. During phase 1 it sends its own low-frequency, full-swing and post-cursor values and captures the values the partner sends.

In its master phase, the block asks the lanes to evaluate candidate transmitter presets for the remote side. This is phase 2 for the upstream role and phase 3 for the downstream role. Each lane has a request channel (valid/ready) and a result channel (valid/ready). A request holds its valid and its preset until ready is seen. After the handshake the lane issues no new request until a result has been accepted, so a lane never has more than one request open. A lane's result is accepted only while that lane's eval_ready is high, and eval_ready is high only while a request is open. Results arriving at other times are ignored. A per-phase timeout ends a stuck exchange with a failure pulse.

Top module: `eqp_ctrl`

## Requirements
- R1: After reset, phase is 0 (idle), tx_ec is 00, and eq_done, eq_fail and every req_valid are low.
- R2: In idle, start is ignored when rate_ge8 is low, or when bypass_mid is high and rate_is_max is low.
- R3: An accepted start moves the upstream role (dsp_role=0) to phase code 1 (phase 0) and the downstream role to phase code 2 (phase 1). tx_preset shows loc_preset in phase codes 1 and 2 and is zero elsewhere.
- R4: A received control code takes effect only after it appears on two received training sets in a row, with no differing code between them. A single isolated code changes nothing.
- R5: tx_ec is 00 in idle, phase 0 and done; 01 in phase 1; 10 in phase 2; 11 in phase 3. Phase codes are: idle 0, phase 0 = 1, phase 1 = 2, phase 2 = 3, phase 3 = 4, done = 5.
- R6: In phase 1, tx_lf/tx_fs/tx_post show loc_lf/loc_fs/loc_post and are zero elsewhere. Every received training set in phase 1 loads rx_lf/rx_fs/rx_post into rem_lf/rem_fs/rem_post.
- R7: The downstream role in phase 1, on a confirmed 01, goes to done if coarse_ok is high and to phase 2 otherwise. The upstream role in phase 1 goes to phase 2 on a confirmed 10 and to done on a confirmed 00.
- R8: In the master phase, each lane whose evaluation has not passed asserts req_valid with a stable req_preset until req_ready. The preset starts at 0 and goes up by 1 (mod 2^PW) after every failing result. After a handshake, req_valid stays low until the result is taken.
- R9: eval_ready is high exactly while a lane has an open request. eval_valid at any other time has no effect.
- R10: When every lane has passed, the upstream role leaves phase 2 for phase 3 and the downstream role leaves phase 3 for done.
- R11: The downstream role leaves phase 2 for phase 3 on a confirmed 11. The upstream role leaves phase 3 for done on a confirmed 00.
- R12: If the block stays TMO_CYC cycles in any of phases 0 to 3, it returns to idle and pulses eq_fail for one cycle. The timeout overrides any other move in that cycle.
- R13: In done, eq_done is high until start goes low; the block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Enter equalization; level, also held to stay in done |
| dsp_role | input | 1 | 1 = downstream-facing role, 0 = upstream-facing |
| rate_ge8 | input | 1 | Target rate is 8 GT/s or above |
| bypass_mid | input | 1 | Equalize only at the highest rate |
| rate_is_max | input | 1 | Target rate is the highest supported |
| coarse_ok | input | 1 | Preset-stage quality already sufficient |
| rx_ts_valid | input | 1 | A training set was received this cycle |
| rx_ec | input | 2 | Received control code |
| rx_lf | input | VW | Received low-frequency value |
| rx_fs | input | VW | Received full-swing value |
| rx_post | input | VW | Received post-cursor value |
| loc_lf | input | VW | Local low-frequency value |
| loc_fs | input | VW | Local full-swing value |
| loc_post | input | VW | Local post-cursor value |
| loc_preset | input | PW | Local transmitter preset |
| tx_ec | output | 2 | Control code for transmitted training sets |
| tx_lf | output | VW | Low-frequency value to send |
| tx_fs | output | VW | Full-swing value to send |
| tx_post | output | VW | Post-cursor value to send |
| tx_preset | output | PW | Preset reported to the partner |
| rem_lf | output | VW | Captured partner low-frequency value |
| rem_fs | output | VW | Captured partner full-swing value |
| rem_post | output | VW | Captured partner post-cursor value |
| req_valid | output | LANES | Per-lane evaluation request valid |
| req_ready | input | LANES | Per-lane request ready |
| req_preset | output | LANES*PW | Per-lane requested remote preset |
| eval_valid | input | LANES | Per-lane result valid |
| eval_ready | output | LANES | Per-lane result ready |
| eval_pass | input | LANES | Per-lane result: quality met |
| phase | output | 3 | Current phase code |
| eq_done | output | 1 | Equalization finished |
| eq_fail | output | 1 | One-cycle pulse on timeout |

## Verification
The hardest case to reach is the master phase with open requests under back-pressure, while stray results arrive on lanes that have no open request. To get there, the stimulus first walks both roles through the confirmed code exchanges. It then holds req_ready low on a repeating pattern and drives eval_valid with passing results whenever a lane is not waiting. It also tests a lone control code flanked by a differing one, and a lane whose target preset can never be reached, which forces a timeout from inside the master phase.

// File: rtl/eqp_pkg.sv
package eqp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_P0   = 3'd1,
    PH_P1   = 3'd2,
    PH_P2   = 3'd3,
    PH_P3   = 3'd4,
    PH_DONE = 3'd5
  } eq_phase_e;

  localparam logic [1:0] EC_00 = 2'b00;
  localparam logic [1:0] EC_01 = 2'b01;
  localparam logic [1:0] EC_10 = 2'b10;
  localparam logic [1:0] EC_11 = 2'b11;

  function automatic logic [1:0] ec_for(eq_phase_e p);
    case (p)
      PH_P1:   return EC_01;
      PH_P2:   return EC_10;
      PH_P3:   return EC_11;
      default: return EC_00;
    endcase
  endfunction
endpackage

// File: rtl/eqp_code_filter.sv
module eqp_code_filter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       ts_valid,
  input  logic [1:0] code_in,
  output logic       conf_vld,
  output logic [1:0] conf_code
);
  logic [1:0] last_q;
  logic       have_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      last_q    <= '0;
      have_q    <= 1'b0;
      conf_vld  <= 1'b0;
      conf_code <= '0;
    end else if (ts_valid) begin
      if (have_q && code_in == last_q) begin
        conf_vld  <= 1'b1;
        conf_code <= code_in;
      end
      last_q <= code_in;
      have_q <= 1'b1;
    end
  end

  // R4
  confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conf_vld) |-> $past(ts_valid));
endmodule

// File: rtl/eqp_timer.sv
module eqp_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !active) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  assign expired = active && (cnt == CW'(LIMIT - 1));

  // R12
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));
endmodule

// File: rtl/eqp_lane.sv
module eqp_lane #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [PW-1:0] req_preset,
  input  logic          eval_valid,
  output logic          eval_ready,
  input  logic          eval_pass,
  output logic          lane_done
);
  logic          outst, done_q;
  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      outst  <= 1'b0;
      done_q <= 1'b0;
      pre_q  <= '0;
    end else if (outst) begin
      if (eval_valid) begin
        outst <= 1'b0;
        if (eval_pass) done_q <= 1'b1;
        else           pre_q  <= pre_q + 1'b1;
      end
    end else if (!done_q && req_ready) begin
      outst <= 1'b1;
    end
  end

  assign req_valid  = run && !done_q && !outst;
  assign eval_ready = outst;
  assign req_preset = pre_q;
  assign lane_done  = done_q;

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (!run || (req_valid && $stable(req_preset))));
  // R8
  one_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);
endmodule

// File: rtl/eqp_ctrl.sv
module eqp_ctrl #(
  parameter int LANES   = 4,
  parameter int PW      = 4,
  parameter int VW      = 6,
  parameter int TMO_CYC = 4096
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                dsp_role,
  input  logic                rate_ge8,
  input  logic                bypass_mid,
  input  logic                rate_is_max,
  input  logic                coarse_ok,
  input  logic                rx_ts_valid,
  input  logic [1:0]          rx_ec,
  input  logic [VW-1:0]       rx_lf,
  input  logic [VW-1:0]       rx_fs,
  input  logic [VW-1:0]       rx_post,
  input  logic [VW-1:0]       loc_lf,
  input  logic [VW-1:0]       loc_fs,
  input  logic [VW-1:0]       loc_post,
  input  logic [PW-1:0]       loc_preset,
  output logic [1:0]          tx_ec,
  output logic [VW-1:0]       tx_lf,
  output logic [VW-1:0]       tx_fs,
  output logic [VW-1:0]       tx_post,
  output logic [PW-1:0]       tx_preset,
  output logic [VW-1:0]       rem_lf,
  output logic [VW-1:0]       rem_fs,
  output logic [VW-1:0]       rem_post,
  output logic [LANES-1:0]    req_valid,
  input  logic [LANES-1:0]    req_ready,
  output logic [LANES*PW-1:0] req_preset,
  input  logic [LANES-1:0]    eval_valid,
  output logic [LANES-1:0]    eval_ready,
  input  logic [LANES-1:0]    eval_pass,
  output logic [2:0]          phase,
  output logic                eq_done,
  output logic                eq_fail
);
  import eqp_pkg::*;

  eq_phase_e st, nxt;
  logic conf_vld, expired, in_phase, master, all_pass, elig;
  logic [1:0] conf_code;
  logic [LANES-1:0] lane_done;

  assign elig     = rate_ge8 && (!bypass_mid || rate_is_max);
  assign in_phase = (st == PH_P0) || (st == PH_P1) || (st == PH_P2) || (st == PH_P3);
  assign master   = dsp_role ? (st == PH_P3) : (st == PH_P2);
  assign all_pass = master && (&lane_done);

  eqp_code_filter u_filt (
    .clk(clk), .rst_n(rst_n), .clr(st == PH_IDLE), .ts_valid(rx_ts_valid),
    .code_in(rx_ec), .conf_vld(conf_vld), .conf_code(conf_code)
  );

  eqp_timer #(.LIMIT(TMO_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .active(in_phase), .restart(nxt != st),
    .expired(expired)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    eqp_lane #(.PW(PW)) u_lane (
      .clk(clk), .rst_n(rst_n), .run(master),
      .req_valid(req_valid[l]), .req_ready(req_ready[l]),
      .req_preset(req_preset[l*PW +: PW]),
      .eval_valid(eval_valid[l]), .eval_ready(eval_ready[l]),
      .eval_pass(eval_pass[l]), .lane_done(lane_done[l])
    );
  end

  always_comb begin
    nxt = st;
    case (st)
      PH_IDLE: if (start && elig) nxt = dsp_role ? PH_P1 : PH_P0;
      PH_P0:   if (conf_vld && conf_code == EC_01) nxt = PH_P1;
      PH_P1: begin
        if (dsp_role) begin
          if (conf_vld && conf_code == EC_01) nxt = coarse_ok ? PH_DONE : PH_P2;
        end else if (conf_vld && conf_code == EC_10) nxt = PH_P2;
        else if (conf_vld && conf_code == EC_00)     nxt = PH_DONE;
      end
      PH_P2: begin
        if (dsp_role) begin
          if (conf_vld && conf_code == EC_11) nxt = PH_P3;
        end else if (all_pass) nxt = PH_P3;
      end
      PH_P3: begin
        if (dsp_role) begin
          if (all_pass) nxt = PH_DONE;
        end else if (conf_vld && conf_code == EC_00) nxt = PH_DONE;
      end
      PH_DONE: if (!start) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
    if (expired) nxt = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PH_IDLE;
      eq_fail  <= 1'b0;
      rem_lf   <= '0;
      rem_fs   <= '0;
      rem_post <= '0;
    end else begin
      st      <= nxt;
      eq_fail <= expired;
      if (st == PH_P1 && rx_ts_valid) begin
        rem_lf   <= rx_lf;
        rem_fs   <= rx_fs;
        rem_post <= rx_post;
      end
    end
  end

  assign phase     = st;
  assign tx_ec     = ec_for(st);
  assign eq_done   = (st == PH_DONE);
  assign tx_lf     = (st == PH_P1) ? loc_lf   : '0;
  assign tx_fs     = (st == PH_P1) ? loc_fs   : '0;
  assign tx_post   = (st == PH_P1) ? loc_post : '0;
  assign tx_preset = (st == PH_P0 || st == PH_P1) ? loc_preset : '0;

  // R12
  fail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eq_fail |-> (st == PH_IDLE));
  // R13
  done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eq_done) |-> ($past(st) == PH_P1 || $past(st) == PH_P3));
  // R2
  idle_inelig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_IDLE && !elig) |=> (st == PH_IDLE));
endmodule

// File: tb/eqp_ctrl_test.sv
module eqp_ctrl_test;
  localparam int L = 2, PW = 4, VW = 6, LIM = 60;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic start = 0, dsp_role = 0, rate_ge8 = 1, bypass_mid = 0, rate_is_max = 1, coarse_ok = 0;
  logic rx_ts_valid = 0;
  logic [1:0] rx_ec = 0;
  logic [VW-1:0] rx_lf = 0, rx_fs = 0, rx_post = 0;
  logic [VW-1:0] loc_lf = 6'd9, loc_fs = 6'd45, loc_post = 6'd3;
  logic [PW-1:0] loc_preset = 4'd7;
  logic [1:0] tx_ec;
  logic [VW-1:0] tx_lf, tx_fs, tx_post, rem_lf, rem_fs, rem_post;
  logic [PW-1:0] tx_preset;
  logic [L-1:0] req_valid, req_ready = 0, eval_valid = 0, eval_ready, eval_pass = 0;
  logic [L*PW-1:0] req_preset;
  logic [2:0] phase;
  logic eq_done, eq_fail;

  eqp_ctrl #(.LANES(L), .PW(PW), .VW(VW), .TMO_CYC(LIM)) uut (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit cmp_on = 0, stray = 0;
  int tgt[L];

  // behavioural reference model
  int m_st = 0, m_cyc = 0, m_last = 0, m_have = 0, m_conf = 0, m_cvld = 0;
  int m_rlf = 0, m_rfs = 0, m_rpo = 0;
  bit m_fail = 0;
  int m_done[L], m_out[L], m_pre[L];

  function automatic bit m_master(int s);
    return dsp_role ? (s == 4) : (s == 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cyc = 0; m_last = 0; m_have = 0; m_conf = 0; m_cvld = 0;
      m_rlf = 0; m_rfs = 0; m_rpo = 0; m_fail = 0;
      for (int l = 0; l < L; l++) begin m_done[l] = 0; m_out[l] = 0; m_pre[l] = 0; end
    end else begin
      automatic int ns = m_st;
      automatic bit allp = m_master(m_st);
      automatic bit elig = rate_ge8 && (!bypass_mid || rate_is_max);
      for (int l = 0; l < L; l++) if (!m_done[l]) allp = 0;
      case (m_st)
        0: if (start && elig) ns = dsp_role ? 2 : 1;
        1: if (m_cvld && m_conf == 1) ns = 2;
        2: if (dsp_role) begin if (m_cvld && m_conf == 1) ns = coarse_ok ? 5 : 3; end
           else if (m_cvld && m_conf == 2) ns = 3;
           else if (m_cvld && m_conf == 0) ns = 5;
        3: if (dsp_role) begin if (m_cvld && m_conf == 3) ns = 4; end
           else if (allp) ns = 4;
        4: if (dsp_role) begin if (allp) ns = 5; end
           else if (m_cvld && m_conf == 0) ns = 5;
        5: if (!start) ns = 0;
        default: ns = 0;
      endcase
      m_fail = 0;
      if (m_st >= 1 && m_st <= 4 && m_cyc == LIM - 1) begin ns = 0; m_fail = 1; end
      for (int l = 0; l < L; l++) begin
        if (!m_master(m_st)) begin m_done[l] = 0; m_out[l] = 0; m_pre[l] = 0; end
        else if (m_out[l]) begin
          if (eval_valid[l]) begin
            m_out[l] = 0;
            if (eval_pass[l]) m_done[l] = 1; else m_pre[l] = (m_pre[l] + 1) % 16;
          end
        end else if (!m_done[l] && req_ready[l]) m_out[l] = 1;
      end
      if (m_st == 0) begin m_last = 0; m_have = 0; m_conf = 0; m_cvld = 0; end
      else if (rx_ts_valid) begin
        if (m_have && rx_ec == m_last) begin m_conf = rx_ec; m_cvld = 1; end
        m_last = rx_ec; m_have = 1;
      end
      if (m_st == 2 && rx_ts_valid) begin m_rlf = rx_lf; m_rfs = rx_fs; m_rpo = rx_post; end
      if (ns != m_st || m_st < 1 || m_st > 4) m_cyc = 0; else m_cyc++;
      m_st = ns;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic cmp(input longint act, input longint exp, input string tag);
    chk(act == exp, tag, act, exp);
  endtask

  // responder and per-cycle comparison, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    req_ready <= {L{(cyc % 3) != 0}};
    for (int l = 0; l < L; l++) begin
      eval_valid[l] <= m_out[l] ? 1'b1 : stray;
      eval_pass[l]  <= m_out[l] ? (m_pre[l] >= tgt[l]) : 1'b1;
    end
    if (cmp_on && rst_n) begin
      automatic logic [L-1:0] erv = '0, ery = '0;
      automatic logic [L*PW-1:0] epr = '0;
      automatic int ec = (m_st == 2) ? 1 : (m_st == 3) ? 2 : (m_st == 4) ? 3 : 0;
      for (int l = 0; l < L; l++) begin
        erv[l] = m_master(m_st) && !m_done[l] && !m_out[l];
        ery[l] = m_out[l] != 0;
        epr[l*PW +: PW] = PW'(m_pre[l]);
      end
      cmp(phase, m_st, "R7 phase");
      cmp(tx_ec, ec, "R5 tx_ec");
      cmp(eq_done, m_st == 5, "R13 eq_done");
      cmp(eq_fail, m_fail, "R12 eq_fail");
      cmp(tx_lf, (m_st == 2) ? loc_lf : 0, "R6 tx_lf");
      cmp(tx_fs, (m_st == 2) ? loc_fs : 0, "R6 tx_fs");
      cmp(tx_post, (m_st == 2) ? loc_post : 0, "R6 tx_post");
      cmp(tx_preset, (m_st == 1 || m_st == 2) ? loc_preset : 0, "R3 tx_preset");
      cmp(rem_lf, m_rlf, "R6 rem_lf");
      cmp(rem_fs, m_rfs, "R6 rem_fs");
      cmp(rem_post, m_rpo, "R6 rem_post");
      cmp(req_valid, erv, "R8 req_valid");
      cmp(req_preset, epr, "R8 req_preset");
      cmp(eval_ready, ery, "R9 eval_ready");
    end
  end

  task automatic send_ts(input int code, input int n, input int lf = 0, input int fs = 0, input int po = 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_ts_valid = 1; rx_ec = 2'(code); rx_lf = VW'(lf); rx_fs = VW'(fs); rx_post = VW'(po);
    end
    @(negedge clk);
    rx_ts_valid = 0;
  endtask

  task automatic wait_ph(input int p, input string tag);
    int k = 0;
    while (phase != 3'(p) && k < 200) begin @(negedge clk); k++; end
    @(negedge clk);
    cmp(phase, p, tag);
  endtask

  task automatic wait_fail(input string tag);
    int k = 0;
    bit seen = 0;
    while (!seen && k < 200) begin @(negedge clk); seen = eq_fail; k++; end
    chk(seen, tag, seen, 1);
    cmp(phase, 0, tag);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tgt[0] = 0; tgt[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cmp(phase, 0, "R1 phase");
    cmp(tx_ec, 0, "R1 tx_ec");
    cmp(eq_done, 0, "R1 eq_done");
    cmp(eq_fail, 0, "R1 eq_fail");
    cmp(req_valid, 0, "R1 req_valid");
    cmp_on = 1;

    // R2 ineligible rate and bypass
    rate_ge8 = 0; start = 1;
    repeat (8) @(negedge clk);
    cmp(phase, 0, "R2 low rate");
    rate_ge8 = 1; bypass_mid = 1; rate_is_max = 0;
    repeat (8) @(negedge clk);
    cmp(phase, 0, "R2 bypass");
    start = 0; bypass_mid = 0; rate_is_max = 1;
    @(negedge clk);

    // downstream full run
    dsp_role = 1; tgt[0] = 2; tgt[1] = 0;
    start = 1;
    wait_ph(2, "R3 dsp start");
    send_ts(1, 1);
    @(negedge clk);
    send_ts(2, 1);
    repeat (3) @(negedge clk);
    cmp(phase, 2, "R4 isolated code");
    send_ts(1, 2);
    wait_ph(3, "R7 dsp to p2");
    send_ts(3, 2);
    stray = 1;
    wait_ph(4, "R11 dsp to p3");
    wait_ph(5, "R10 dsp all pass");
    stray = 0;
    repeat (3) @(negedge clk);
    cmp(eq_done, 1, "R13 hold done");
    start = 0;
    wait_ph(0, "R13 back to idle");

    // upstream full run
    dsp_role = 0; tgt[0] = 0; tgt[1] = 3;
    start = 1;
    wait_ph(1, "R3 usp start");
    cmp(tx_preset, 7, "R3 preset report");
    send_ts(1, 2);
    wait_ph(2, "R7 usp to p1");
    send_ts(1, 2, 5, 40, 7);
    @(negedge clk);
    cmp(rem_lf, 5, "R6 capture lf");
    cmp(rem_fs, 40, "R6 capture fs");
    send_ts(2, 2);
    wait_ph(3, "R7 usp to p2");
    wait_ph(4, "R10 usp all pass");
    send_ts(0, 2);
    wait_ph(5, "R11 usp done");
    start = 0;
    wait_ph(0, "R13 usp idle");

    // coarse-stage skips
    dsp_role = 1; coarse_ok = 1; start = 1;
    wait_ph(2, "R3 dsp coarse");
    send_ts(1, 2);
    wait_ph(5, "R7 dsp skip");
    start = 0; coarse_ok = 0;
    wait_ph(0, "R13 idle");
    dsp_role = 0; start = 1;
    wait_ph(1, "R3 usp coarse");
    send_ts(1, 2);
    wait_ph(2, "R7 usp p1");
    send_ts(0, 2);
    wait_ph(5, "R7 usp skip");
    start = 0;
    wait_ph(0, "R13 idle");

    // timeouts: waiting in phase 0, and stuck in master phase
    dsp_role = 0; start = 1;
    wait_ph(1, "R3 usp");
    start = 0;
    wait_fail("R12 timeout p0");
    dsp_role = 1; tgt[0] = 0; tgt[1] = 16; start = 1;
    wait_ph(2, "R3 dsp");
    send_ts(1, 2);
    wait_ph(3, "R7 dsp");
    send_ts(3, 2);
    wait_ph(4, "R11 dsp");
    start = 0;
    wait_fail("R12 timeout master");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule